// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware part of entering an exception handler on a processor core. The pipeline hands it one event at a time: a non-maskable interrupt, a maskable interrupt, a fast interrupt, or an unconditional software trap. A software trap is either a numbered trap or a break. Along with the event it receives the current status word, the current and next program counter, the interrupt stack pointer, the accepted priority level, and a flag that says whether the interrupted instruction was a resumable string or repeat operation.

The sequencer first saves the old status word. For a fast interrupt it then writes both copies into backup registers in one cycle and takes its target from a dedicated fast-vector input. For every other event it pushes the status word and then the return address onto the interrupt stack, and then reads the handler address from memory. When the sequence ends, it presents the rewritten status word, the new program counter and the new stack pointer for one cycle.

Every memory access is a request held until its ready input is seen. The block raises busy from the cycle after it accepts an event until its done cycle. It ignores event requests while it is busy.

Top module: `exc_entry_seq`

## Requirements
- R1: An event is accepted only when `ev_valid` is high and `busy` is low. `busy` rises on the next cycle and stays high through a single-cycle `done` pulse. A request made while `busy` is high, including the `done` cycle, is ignored.
- R2: For a non-maskable interrupt, a maskable interrupt or a trap (`ev_type` 0, 1 or 3), exactly two stack writes occur. The first stores the old status word at `isp_in`-4. The second stores the return address at `isp_in`-8. `isp_out` then equals `isp_in`-8.
- R3: For a fast interrupt (`ev_type` 2), `bpsw_we` and `bpc_we` pulse together in one cycle, carrying the old status word and the return address. No stack write and no memory read take place. `isp_out` equals `isp_in`, and `pc_out` equals `fast_vec`.
- R4: The new status word is the old one with the mode bit (bit 20), the stack-select bit (bit 17) and the interrupt-enable bit (bit 16) cleared.
- R5: The priority field (bits 27:24) becomes 0xF for a non-maskable interrupt and becomes `ev_level` for maskable and fast interrupts. A trap leaves the field unchanged.
- R6: For the three interrupt kinds, the return address is `cur_pc` when `ev_in_string` is 1 and `next_pc` otherwise. A trap always uses `next_pc`.
- R7: The vector read address depends on the event. A non-maskable interrupt reads `exc_base`+0x78. A maskable interrupt, and a numbered trap (`ev_brk`=0), read `int_base`+4*`ev_vnum`. A break (`ev_brk`=1) reads `int_base`.
- R8: `pc_out` in the `done` cycle equals the data returned by the vector read.
- R9: A pending write holds its address and data until `mem_wready` is seen. A pending read holds its address until `mem_rready` is seen. A write and a read are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event request |
| ev_type | input | 2 | 0 non-maskable, 1 maskable, 2 fast, 3 trap |
| ev_brk | input | 1 | Trap is a break rather than a numbered trap |
| ev_vnum | input | 8 | Vector number for a maskable interrupt or numbered trap |
| ev_level | input | 4 | Accepted priority level of a maskable or fast interrupt |
| ev_in_string | input | 1 | Interrupted instruction is a resumable string/repeat op |
| cur_psw | input | 32 | Status word before entry |
| cur_pc | input | 32 | Address of the interrupted instruction |
| next_pc | input | 32 | Address of the following instruction |
| isp_in | input | 32 | Interrupt stack pointer before entry |
| exc_base | input | 32 | Exception table base |
| int_base | input | 32 | Interrupt vector table base |
| fast_vec | input | 32 | Fast interrupt target address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle, results valid |
| mem_wr | output | 1 | Stack write request |
| mem_waddr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| mem_wready | input | 1 | Stack write accepted |
| mem_rd | output | 1 | Vector read request |
| mem_raddr | output | 32 | Vector read address |
| mem_rdata | input | 32 | Vector read data |
| mem_rready | input | 1 | Vector read data valid |
| bpsw_we | output | 1 | Backup status word write |
| bpsw_d | output | 32 | Backup status word value |
| bpc_we | output | 1 | Backup return address write |
| bpc_d | output | 32 | Backup return address value |
| psw_out | output | 32 | New status word |
| pc_out | output | 32 | Handler address |
| isp_out | output | 32 | New stack pointer |

## Verification
Two things can fall in the same cycle: the `done` pulse of one sequence and a fresh `ev_valid` from the pipeline. The bench raises a request of a different kind exactly in the cycle where `done` is seen, and another request in the middle of a sequence. It then judges at the ports that `busy` falls and stays low, and that no further stack write or read appears. It also judges that the finished sequence produced only its own two pushes and its own vector read. Memory latency is varied so that waiting states overlap these injections.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      EV_NMI  = 2'd0,
      EV_IRQ  = 2'd1,
      EV_FAST = 2'd2,
      EV_TRAP = 2'd3
   } ev_kind_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_SR = 3'd1,
      ST_PUSH_PC = 3'd2,
      ST_BACKUP  = 3'd3,
      ST_FETCH   = 3'd4,
      ST_FIN     = 3'd5
   } seq_state_t;

endpackage

// File: rtl/exc_psw_xform.sv
module exc_psw_xform
   import exc_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IE_BIT  = 16,
   parameter int SS_BIT  = 17,
   parameter int PM_BIT  = 20,
   parameter int IPL_LSB = 24,
   parameter int IPL_W   = 4
) (
   input  ev_kind_t           kind,
   input  logic [IPL_W-1:0]   level,
   input  logic [XLEN-1:0]    psw_in,
   output logic [XLEN-1:0]    psw_new
);
   localparam int NCLR = 3;
   localparam int CLR_POS [NCLR] = '{IE_BIT, SS_BIT, PM_BIT};

   logic [XLEN-1:0] clr_mask;
   logic [XLEN-1:0] cleared;

   for (genvar g = 0; g < XLEN; g++) begin : g_mask
      assign clr_mask[g] = (g == CLR_POS[0]) || (g == CLR_POS[1]) || (g == CLR_POS[2]);
   end

   assign cleared = psw_in & ~clr_mask;

   always_comb begin
      psw_new = cleared;
      unique case (kind)
         EV_NMI:  psw_new[IPL_LSB +: IPL_W] = {IPL_W{1'b1}};
         EV_IRQ,
         EV_FAST: psw_new[IPL_LSB +: IPL_W] = level;
         default: psw_new[IPL_LSB +: IPL_W] = cleared[IPL_LSB +: IPL_W];
      endcase
   end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
   import exc_entry_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          VNUM_W    = 8,
   parameter int          VEC_BYTES = 4,
   parameter logic [31:0] NMI_OFS   = 32'h78
) (
   input  ev_kind_t            kind,
   input  logic                brk,
   input  logic [VNUM_W-1:0]   vnum,
   input  logic                in_string,
   input  logic [XLEN-1:0]     cur_pc,
   input  logic [XLEN-1:0]     next_pc,
   input  logic [XLEN-1:0]     exc_base,
   input  logic [XLEN-1:0]     int_base,
   output logic [XLEN-1:0]     vaddr,
   output logic [XLEN-1:0]     save_pc
);
   localparam bit POW2   = (VEC_BYTES & (VEC_BYTES - 1)) == 0;
   localparam int VSHIFT = $clog2(VEC_BYTES);

   logic [XLEN-1:0] slot_ofs;
   logic [XLEN-1:0] vnum_x;

   assign vnum_x = XLEN'(vnum);

   if (POW2) begin : g_shift
      assign slot_ofs = vnum_x << VSHIFT;
   end else begin : g_mult
      assign slot_ofs = vnum_x * XLEN'(VEC_BYTES);
   end

   always_comb begin
      unique case (kind)
         EV_NMI:  vaddr = exc_base + XLEN'(NMI_OFS);
         EV_TRAP: vaddr = brk ? int_base : int_base + slot_ofs;
         default: vaddr = int_base + slot_ofs;
      endcase
   end

   always_comb begin
      if (kind != EV_TRAP && in_string) save_pc = cur_pc;
      else                              save_pc = next_pc;
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_fast,
   input  logic wr_ready,
   input  logic rd_ready,
   output logic idle,
   output logic push_sr,
   output logic push_pc,
   output logic backup,
   output logic fetch,
   output logic fin
);
   seq_state_t st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    if (start) st_nx = start_fast ? ST_BACKUP : ST_PUSH_SR;
         ST_PUSH_SR: if (wr_ready) st_nx = ST_PUSH_PC;
         ST_PUSH_PC: if (wr_ready) st_nx = ST_FETCH;
         ST_BACKUP:  st_nx = ST_FIN;
         ST_FETCH:   if (rd_ready) st_nx = ST_FIN;
         ST_FIN:     st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign idle    = (st == ST_IDLE);
   assign push_sr = (st == ST_PUSH_SR);
   assign push_pc = (st == ST_PUSH_PC);
   assign backup  = (st == ST_BACKUP);
   assign fetch   = (st == ST_FETCH);
   assign fin     = (st == ST_FIN);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          VNUM_W    = 8,
   parameter int          IPL_W     = 4,
   parameter int          IE_BIT    = 16,
   parameter int          SS_BIT    = 17,
   parameter int          PM_BIT    = 20,
   parameter int          IPL_LSB   = 24,
   parameter int          VEC_BYTES = 4,
   parameter logic [31:0] NMI_OFS   = 32'h78
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [1:0]        ev_type,
   input  logic              ev_brk,
   input  logic [VNUM_W-1:0] ev_vnum,
   input  logic [IPL_W-1:0]  ev_level,
   input  logic              ev_in_string,
   input  logic [XLEN-1:0]   cur_psw,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   next_pc,
   input  logic [XLEN-1:0]   isp_in,
   input  logic [XLEN-1:0]   exc_base,
   input  logic [XLEN-1:0]   int_base,
   input  logic [XLEN-1:0]   fast_vec,
   output logic              busy,
   output logic              done,
   output logic              mem_wr,
   output logic [XLEN-1:0]   mem_waddr,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic              mem_wready,
   output logic              mem_rd,
   output logic [XLEN-1:0]   mem_raddr,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_rready,
   output logic              bpsw_we,
   output logic [XLEN-1:0]   bpsw_d,
   output logic              bpc_we,
   output logic [XLEN-1:0]   bpc_d,
   output logic [XLEN-1:0]   psw_out,
   output logic [XLEN-1:0]   pc_out,
   output logic [XLEN-1:0]   isp_out
);
   localparam int          SLOT_BYTES = XLEN / 8;
   localparam logic [XLEN-1:0] SLOT   = XLEN'(SLOT_BYTES);

   if (XLEN % 8 != 0)                 $error("XLEN must be a whole number of bytes");
   if (IPL_LSB + IPL_W > XLEN)        $error("priority field lies outside the status word");
   if (IE_BIT >= XLEN || SS_BIT >= XLEN || PM_BIT >= XLEN)
                                      $error("status bit position out of range");
   if (VEC_BYTES < 1)                 $error("vector entry size must be positive");
   if (VNUM_W < 1 || VNUM_W > XLEN)   $error("vector number width out of range");

   ev_kind_t kind;
   assign kind = ev_kind_t'(ev_type);

   logic idle, push_sr, push_pc, backup, fetch, fin;
   logic accept;
   logic [XLEN-1:0] xf_psw, vs_addr, vs_pc;

   assign accept = ev_valid && idle;

   exc_entry_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_fast (kind == EV_FAST),
      .wr_ready   (mem_wready),
      .rd_ready   (mem_rready),
      .idle       (idle),
      .push_sr    (push_sr),
      .push_pc    (push_pc),
      .backup     (backup),
      .fetch      (fetch),
      .fin        (fin)
   );

   exc_psw_xform #(
      .XLEN(XLEN), .IE_BIT(IE_BIT), .SS_BIT(SS_BIT), .PM_BIT(PM_BIT),
      .IPL_LSB(IPL_LSB), .IPL_W(IPL_W)
   ) u_xform (
      .kind    (kind),
      .level   (ev_level),
      .psw_in  (cur_psw),
      .psw_new (xf_psw)
   );

   exc_vec_sel #(
      .XLEN(XLEN), .VNUM_W(VNUM_W), .VEC_BYTES(VEC_BYTES), .NMI_OFS(NMI_OFS)
   ) u_vsel (
      .kind      (kind),
      .brk       (ev_brk),
      .vnum      (ev_vnum),
      .in_string (ev_in_string),
      .cur_pc    (cur_pc),
      .next_pc   (next_pc),
      .exc_base  (exc_base),
      .int_base  (int_base),
      .vaddr     (vs_addr),
      .save_pc   (vs_pc)
   );

   logic [XLEN-1:0] isp_r, sr_save, pc_save, vaddr_r, fvec_r, psw_r, pc_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isp_r   <= '0;
         sr_save <= '0;
         pc_save <= '0;
         vaddr_r <= '0;
         fvec_r  <= '0;
         psw_r   <= '0;
         pc_r    <= '0;
      end else begin
         if (accept) begin
            isp_r   <= isp_in;
            sr_save <= cur_psw;
            pc_save <= vs_pc;
            vaddr_r <= vs_addr;
            fvec_r  <= fast_vec;
            psw_r   <= xf_psw;
         end
         if ((push_sr || push_pc) && mem_wready) isp_r <= isp_r - SLOT;
         if (fetch && mem_rready) pc_r <= mem_rdata;
         if (backup)              pc_r <= fvec_r;
      end
   end

   assign busy      = !idle;
   assign done      = fin;
   assign mem_wr    = push_sr || push_pc;
   assign mem_waddr = isp_r - SLOT;
   assign mem_wdata = push_sr ? sr_save : pc_save;
   assign mem_rd    = fetch;
   assign mem_raddr = vaddr_r;
   assign bpsw_we   = backup;
   assign bpsw_d    = sr_save;
   assign bpc_we    = backup;
   assign bpc_d     = pc_save;
   assign psw_out   = psw_r;
   assign pc_out    = pc_r;
   assign isp_out   = isp_r;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN    = 32,
   parameter int IE_BIT  = 16,
   parameter int SS_BIT  = 17,
   parameter int PM_BIT  = 20,
   parameter int IPL_LSB = 24,
   parameter int IPL_W   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ev_valid,
   input logic [1:0]      ev_type,
   input logic            busy,
   input logic            done,
   input logic            mem_wr,
   input logic [XLEN-1:0] mem_waddr,
   input logic [XLEN-1:0] mem_wdata,
   input logic            mem_wready,
   input logic            mem_rd,
   input logic [XLEN-1:0] mem_raddr,
   input logic            mem_rready,
   input logic            bpsw_we,
   input logic            bpc_we,
   input logic [XLEN-1:0] psw_out
);
   logic [1:0] kind_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                kind_r <= 2'd0;
      else if (ev_valid && !busy) kind_r <= ev_type;
   end

   p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !busy |=> busy);

   p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   p_fast_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && kind_r == 2'd2 |-> !mem_wr && !mem_rd);

   p_backup_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bpsw_we |-> bpc_we);

   p_psw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !psw_out[IE_BIT] && !psw_out[SS_BIT] && !psw_out[PM_BIT]);

   p_nmi_ipl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done && kind_r == 2'd0 |-> psw_out[IPL_LSB +: IPL_W] == {IPL_W{1'b1}});

   p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && !mem_wready |=> mem_wr && $stable(mem_waddr) && $stable(mem_wdata));

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_rready |=> mem_rd && $stable(mem_raddr));

   p_wr_rd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));
endmodule

bind exc_entry_seq exc_entry_chk #(
   .XLEN(XLEN), .IE_BIT(IE_BIT), .SS_BIT(SS_BIT), .PM_BIT(PM_BIT),
   .IPL_LSB(IPL_LSB), .IPL_W(IPL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid   (ev_valid),
   .ev_type    (ev_type),
   .busy       (busy),
   .done       (done),
   .mem_wr     (mem_wr),
   .mem_waddr  (mem_waddr),
   .mem_wdata  (mem_wdata),
   .mem_wready (mem_wready),
   .mem_rd     (mem_rd),
   .mem_raddr  (mem_raddr),
   .mem_rready (mem_rready),
   .bpsw_we    (bpsw_we),
   .bpc_we     (bpc_we),
   .psw_out    (psw_out)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [1:0]  ev_type = 2'd0;
   logic        ev_brk = 1'b0;
   logic [7:0]  ev_vnum = 8'd0;
   logic [3:0]  ev_level = 4'd0;
   logic        ev_in_string = 1'b0;
   logic [31:0] cur_psw = '0, cur_pc = '0, next_pc = '0, isp_in = '0;
   logic [31:0] exc_base = 32'hFFFF_FF80;
   logic [31:0] int_base = 32'h0001_0000;
   logic [31:0] fast_vec = 32'h0000_BEE0;
   logic        busy, done, mem_wr, mem_rd, bpsw_we, bpc_we;
   logic [31:0] mem_waddr, mem_wdata, mem_raddr, mem_rdata, bpsw_d, bpc_d;
   logic [31:0] psw_out, pc_out, isp_out;
   logic        mem_wready = 1'b0, mem_rready = 1'b0;

   localparam logic [31:0] RKEY = 32'h5A00_0003;

   always #10 clk = ~clk;

   assign mem_rdata = mem_raddr ^ RKEY;

   exc_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type), .ev_brk(ev_brk),
      .ev_vnum(ev_vnum), .ev_level(ev_level), .ev_in_string(ev_in_string),
      .cur_psw(cur_psw), .cur_pc(cur_pc), .next_pc(next_pc), .isp_in(isp_in),
      .exc_base(exc_base), .int_base(int_base), .fast_vec(fast_vec),
      .busy(busy), .done(done), .mem_wr(mem_wr), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .mem_wready(mem_wready), .mem_rd(mem_rd),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
      .bpsw_we(bpsw_we), .bpsw_d(bpsw_d), .bpc_we(bpc_we), .bpc_d(bpc_d),
      .psw_out(psw_out), .pc_out(pc_out), .isp_out(isp_out)
   );

   int checks = 0, errors = 0;
   int lat = 0;
   int wcnt = 0, rcnt = 0;

   // memory model: ready after lat extra cycles
   always @(negedge clk) begin
      if (mem_wr && !mem_wready) begin
         if (wcnt >= lat) mem_wready <= 1'b1; else wcnt++;
      end else begin
         mem_wready <= 1'b0; wcnt = 0;
      end
      if (mem_rd && !mem_rready) begin
         if (rcnt >= lat) mem_rready <= 1'b1; else rcnt++;
      end else begin
         mem_rready <= 1'b0; rcnt = 0;
      end
   end

   logic [31:0] wa [16];
   logic [31:0] wd [16];
   int wn = 0, rn = 0, bn = 0;
   logic [31:0] last_ra, cap_bpsw, cap_bpc;

   always @(posedge clk) begin
      if (mem_wr && mem_wready) begin
         wa[wn % 16] <= mem_waddr; wd[wn % 16] <= mem_wdata; wn <= wn + 1;
      end
      if (mem_rd && mem_rready) begin last_ra <= mem_raddr; rn <= rn + 1; end
      if (bpsw_we) begin cap_bpsw <= bpsw_d; cap_bpc <= bpc_d; bn <= bn + 1; end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_psw(input logic [1:0] ty, input logic [3:0] lvl,
                                           input logic [31:0] p);
      logic [31:0] r;
      r = p & ~32'h0013_0000;
      if (ty == 2'd0)      r[27:24] = 4'hF;
      else if (ty != 2'd3) r[27:24] = lvl;
      return r;
   endfunction

   int w0, r0, b0;
   logic [31:0] f_psw, f_pc, f_isp;

   task automatic run_event(input logic [1:0] ty, input bit brk, input logic [7:0] vn,
                            input logic [3:0] lvl, input bit instr, input logic [31:0] psw,
                            input logic [31:0] cpc, input logic [31:0] npc,
                            input logic [31:0] isp, input bit inj_mid, input bit inj_done);
      int cyc;
      @(negedge clk);
      w0 = wn; r0 = rn; b0 = bn;
      ev_type = ty; ev_brk = brk; ev_vnum = vn; ev_level = lvl; ev_in_string = instr;
      cur_psw = psw; cur_pc = cpc; next_pc = npc; isp_in = isp; ev_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 300) begin
         ev_valid = inj_mid && (cyc == 1);
         if (ev_valid) begin ev_type = 2'd3; ev_brk = 1'b1; end
         @(negedge clk);
         cyc++;
      end
      ev_valid = 1'b0;
      chk(done, "R1", "done reached", 32'(done), 32'd1);
      f_psw = psw_out; f_pc = pc_out; f_isp = isp_out;
      if (inj_done) begin
         ev_type = 2'd0; ev_valid = 1'b1;
      end
      @(negedge clk);
      ev_valid = 1'b0;
      chk(!busy && !done, "R1", "idle after done", {busy, done}, 32'd0);
      if (inj_done) begin
         @(negedge clk);
         chk(!busy && !mem_wr, "R1", "request in done cycle ignored", {busy, mem_wr}, 32'd0);
      end
   endtask

   task automatic t_reset;
      chk(!busy && !done && !mem_wr && !mem_rd && !bpsw_we, "R1", "reset outputs idle",
          {busy, done, mem_wr, mem_rd, bpsw_we}, 32'd0);
   endtask

   task automatic stack_checks(input string tag, input logic [1:0] ty, input logic [3:0] lvl,
                               input logic [31:0] psw, input logic [31:0] spc,
                               input logic [31:0] isp, input logic [31:0] ra);
      chk(wn - w0 == 2, "R2", {tag, " write count"}, 32'(wn - w0), 32'd2);
      chk(wa[w0 % 16] == isp - 4 && wd[w0 % 16] == psw, "R2", {tag, " status push"},
          wa[w0 % 16], isp - 4);
      chk(wa[(w0 + 1) % 16] == isp - 8, "R2", {tag, " pc push addr"}, wa[(w0 + 1) % 16], isp - 8);
      chk(wd[(w0 + 1) % 16] == spc, "R6", {tag, " saved pc"}, wd[(w0 + 1) % 16], spc);
      chk(f_isp == isp - 8, "R2", {tag, " isp_out"}, f_isp, isp - 8);
      chk(rn - r0 == 1 && last_ra == ra, "R7", {tag, " vector addr"}, last_ra, ra);
      chk(f_pc == (ra ^ RKEY), "R8", {tag, " pc_out"}, f_pc, ra ^ RKEY);
      chk(f_psw == exp_psw(ty, lvl, psw), "R4", {tag, " psw_out"}, f_psw, exp_psw(ty, lvl, psw));
      chk(f_psw[27:24] == exp_psw(ty, lvl, psw) >> 24 & 4'hF, "R5", {tag, " ipl"},
          32'(f_psw[27:24]), 32'(exp_psw(ty, lvl, psw)[27:24]));
   endtask

   task automatic t_nmi;
      lat = 0;
      run_event(2'd0, 1'b0, 8'd9, 4'd2, 1'b1, 32'h0213_0005, 32'h100, 32'h104, 32'h2000_1000, 1'b0, 1'b0);
      stack_checks("nmi", 2'd0, 4'd2, 32'h0213_0005, 32'h100, 32'h2000_1000, exc_base + 32'h78);
   endtask

   task automatic t_irq_next;
      lat = 2;
      run_event(2'd1, 1'b0, 8'd37, 4'd5, 1'b0, 32'h0F13_00A0, 32'h200, 32'h203, 32'h3000_0040, 1'b0, 1'b0);
      stack_checks("irq", 2'd1, 4'd5, 32'h0F13_00A0, 32'h203, 32'h3000_0040, int_base + 32'd148);
   endtask

   task automatic t_irq_string;
      lat = 1;
      run_event(2'd1, 1'b0, 8'd0, 4'd1, 1'b1, 32'h0001_0000, 32'h400, 32'h402, 32'h3000_0080, 1'b0, 1'b0);
      stack_checks("irq-string", 2'd1, 4'd1, 32'h0001_0000, 32'h400, 32'h3000_0080, int_base);
   endtask

   task automatic t_fast;
      lat = 3;
      run_event(2'd2, 1'b0, 8'd7, 4'd9, 1'b1, 32'h0112_3456, 32'h500, 32'h504, 32'h3000_1000, 1'b0, 1'b0);
      chk(wn == w0 && rn == r0, "R3", "fast no memory", 32'(wn - w0 + rn - r0), 32'd0);
      chk(bn - b0 == 1 && cap_bpsw == 32'h0112_3456, "R3", "backup psw", cap_bpsw, 32'h0112_3456);
      chk(cap_bpc == 32'h500, "R6", "fast backup pc string", cap_bpc, 32'h500);
      chk(f_pc == fast_vec && f_isp == 32'h3000_1000, "R3", "fast pc/isp", f_pc, fast_vec);
      chk(f_psw == exp_psw(2'd2, 4'd9, 32'h0112_3456), "R5", "fast psw level", f_psw,
          exp_psw(2'd2, 4'd9, 32'h0112_3456));
   endtask

   task automatic t_trap_num;
      lat = 0;
      run_event(2'd3, 1'b0, 8'd255, 4'd3, 1'b1, 32'h0513_0001, 32'h600, 32'h603, 32'h3000_2000, 1'b0, 1'b0);
      stack_checks("trap", 2'd3, 4'd3, 32'h0513_0001, 32'h603, 32'h3000_2000, int_base + 32'd1020);
   endtask

   task automatic t_brk_overlap;
      lat = 1;
      run_event(2'd3, 1'b1, 8'd44, 4'd3, 1'b0, 32'h0A10_0000, 32'h700, 32'h702, 32'h3000_3000, 1'b1, 1'b1);
      stack_checks("brk", 2'd3, 4'd3, 32'h0A10_0000, 32'h702, 32'h3000_3000, int_base);
      chk(wn - w0 == 2 && rn - r0 == 1, "R1", "no extra accesses from injected requests",
          32'(wn - w0), 32'd2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_nmi();
      t_irq_next();
      t_irq_string();
      t_fast();
      t_trap_num();
      t_brk_overlap();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule